// File: doc/BRIEF.md
# Frequency Step Slew Limiter

This block sits on the frequency tuning-word path of a digital synthesis loop. It takes the word from the loop filter and passes it to the interpolation stage. Each time a new tuning word arrives with its valid strobe, the block compares it with the word it emitted last. If the move is larger than a programmed bound, the block lets through only a move of exactly that bound, in the same direction. The synthesized frequency then never changes by more than the bound per update, so its slew rate is set by the bound and the update rate together.

A small configuration register holds an enable flag and the unsigned step bound. Both are loaded together by a write strobe. Reset clears the enable flag and the step bound. While limiting is off, every input word appears on the output unchanged. The emitted word is also the history that the next comparison uses. Because of this, turning limiting on later starts from the frequency currently being produced.

Top module: `freq_slew_limiter`

## Requirements
- R1: After reset, out_valid is 0 and out_word is 0. The stored previous output is 0, limiting is off, and the step bound is 0.
- R2: out_valid is 1 in exactly the cycle after a cycle with in_valid = 1, and 0 otherwise.
- R3: While limiting is off, an accepted in_word appears unchanged on out_word one clock later.
- R4: While limiting is on and in_word exceeds the previous output by more than the bound K, out_word becomes previous + K.
- R5: While limiting is on and in_word is below the previous output by more than K, out_word becomes previous − K.
- R6: While limiting is on and in_word differs from the previous output by at most K in either direction, out_word becomes in_word.
- R7: The difference is formed with one extra sign bit. A move between the lowest and highest word values is clamped by its true size and direction and never wraps.
- R8: A word emitted while limiting is off becomes the previous output for the next limited update.
- R9: With limiting on and K = 0, accepted words leave out_word unchanged.
- R10: out_word holds its value in cycles without in_valid.
- R11: A cycle with cfg_wr = 1 loads the enable flag and K. The new values apply to updates accepted in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Loads cfg_enable and cfg_step into the configuration register |
| cfg_enable | input | 1 | Limiting on (1) or off (0) |
| cfg_step | input | WORD_W | Largest allowed change per update (unsigned) |
| in_valid | input | 1 | New tuning word present |
| in_word | input | WORD_W | Incoming tuning word (unsigned) |
| out_valid | output | 1 | Output word updated this cycle |
| out_word | output | WORD_W | Limited tuning word |

## Verification
The bench builds the limiter with a 6-bit word instead of 48 bits. At that width every previous-output value can be paired with every input value, for bounds of 0, 1, 7 and the all-ones maximum. Each pairing first loads the history through a pass-through update and then applies a limited update. This covers both clamp directions and the exact boundary where the difference equals ±K. It also covers the moves from zero to the top code and back, where a difference without a sign bit would wrap. Directed steps before the sweep check the reset state, the hold behaviour while idle, and the timing of configuration writes.

// File: rtl/slew_pkg.sv
package slew_pkg;

    // Which value the limiter selects for an accepted word
    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,
        SEL_RAISE = 2'd1,
        SEL_LOWER = 2'd2
    } slew_sel_e;

endpackage

// File: rtl/slew_cfg_reg.sv
module slew_cfg_reg #(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              enable_in,
    input  logic [WORD_W-1:0] step_in,
    output logic              enable_q,
    output logic [WORD_W-1:0] step_q
);

    typedef struct packed {
        logic              enable;
        logic [WORD_W-1:0] step;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.enable = enable_in;
            cfg_d.step   = step_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign enable_q = cfg_q.enable;
    assign step_q   = cfg_q.step;

    // R11
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (enable_q == $past(enable_in)) && (step_q == $past(step_in)));

    // R11
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(enable_q) && $stable(step_q));

endmodule

// File: rtl/slew_step_calc.sv
module slew_step_calc
    import slew_pkg::*;
#(
    parameter int WORD_W = 48
) (
    input  logic              enable,
    input  logic [WORD_W-1:0] step,
    input  logic [WORD_W-1:0] in_word,
    input  logic [WORD_W-1:0] last_word,
    output logic [WORD_W-1:0] next_word,
    output slew_sel_e         sel
);

    localparam int EXT_W = WORD_W + 1;

    logic signed [EXT_W-1:0] diff;
    logic signed [EXT_W-1:0] step_pos;
    logic signed [EXT_W-1:0] step_neg;

    always_comb begin
        diff     = $signed({1'b0, in_word}) - $signed({1'b0, last_word});
        step_pos = $signed({1'b0, step});
        step_neg = -step_pos;

        sel = SEL_PASS;
        if (enable) begin
            if (diff > step_pos) begin
                sel = SEL_RAISE;
            end else if (diff < step_neg) begin
                sel = SEL_LOWER;
            end
        end

        unique case (sel)
            SEL_RAISE: next_word = last_word + step;
            SEL_LOWER: next_word = last_word - step;
            default:   next_word = in_word;
        endcase
    end

endmodule

// File: rtl/freq_slew_limiter.sv
module freq_slew_limiter
    import slew_pkg::*;
#(
    parameter int WORD_W = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic              cfg_enable,
    input  logic [WORD_W-1:0] cfg_step,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_word
);

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] word;
    } state_t;

    state_t st_d, st_q;

    logic              en_q;
    logic [WORD_W-1:0] step_q;
    logic [WORD_W-1:0] calc_word;
    slew_sel_e         calc_sel;

    slew_cfg_reg #(.WORD_W(WORD_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (cfg_wr),
        .enable_in (cfg_enable),
        .step_in   (cfg_step),
        .enable_q  (en_q),
        .step_q    (step_q)
    );

    slew_step_calc #(.WORD_W(WORD_W)) u_calc (
        .enable    (en_q),
        .step      (step_q),
        .in_word   (in_word),
        .last_word (st_q.word),
        .next_word (calc_word),
        .sel       (calc_sel)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.word = calc_word;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;

    // R2
    valid_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R3
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !en_q) |=> (out_word == $past(in_word)));

    // R9
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && en_q && (step_q == '0)) |=> $stable(out_word));

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_word));

    // R4 R5
    step_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && en_q) |=>
            ((out_word >= $past(out_word)) ? ((out_word - $past(out_word)) <= $past(step_q))
                                           : (($past(out_word) - out_word) <= $past(step_q))));

endmodule

// File: tb/sim_freq_slew_limiter.sv
module sim_freq_slew_limiter;

    localparam int BW   = 6;
    localparam int WMAX = (1 << BW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_wr = 1'b0;
    logic          cfg_enable = 1'b0;
    logic [BW-1:0] cfg_step = '0;
    logic          in_valid = 1'b0;
    logic [BW-1:0] in_word = '0;
    logic          out_valid;
    logic [BW-1:0] out_word;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    freq_slew_limiter #(.WORD_W(BW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_enable (cfg_enable),
        .cfg_step   (cfg_step),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_word   (out_word)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    function automatic int model(input int last, input int inw, input int k);
        int d;
        d = inw - last;
        if (d > k)  return last + k;
        if (d < -k) return last - k;
        return inw;
    endfunction

    // Load history with 'last' while off, then apply 'inw' with limiting on
    task automatic pair(input int last, input int inw, input int k, input string req);
        cfg_wr = 1'b1; cfg_enable = 1'b0; cfg_step = BW'(k); in_valid = 1'b0;
        tick();
        cfg_wr = 1'b0; in_valid = 1'b1; in_word = BW'(last);
        tick();
        check("R8", int'(out_word), last);
        cfg_wr = 1'b1; cfg_enable = 1'b1; in_valid = 1'b0;
        tick();
        cfg_wr = 1'b0; in_valid = 1'b1; in_word = BW'(inw);
        tick();
        in_valid = 1'b0;
        check(req, int'(out_word), model(last, inw, k));
    endtask

    initial begin
        int kset [4];
        kset[0] = 0; kset[1] = 1; kset[2] = 7; kset[3] = WMAX;

        repeat (3) tick();
        // R1 reset state
        check("R1", int'(out_valid), 0);
        check("R1", int'(out_word), 0);
        rst_n = 1'b1;
        tick();

        // R1 limiting off after reset: a large word passes
        in_valid = 1'b1; in_word = 6'd50;
        tick();
        in_valid = 1'b0;
        check("R2", int'(out_valid), 1);
        check("R1", int'(out_word), 50);
        tick();
        check("R2", int'(out_valid), 0);
        check("R10", int'(out_word), 50);

        // R1 history zero after reset: reset, enable K=3, send 40 -> 3
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_step = 6'd3;
        tick();
        cfg_wr = 1'b0; in_valid = 1'b1; in_word = 6'd40;
        tick();
        in_valid = 1'b0;
        check("R1", int'(out_word), 3);

        // R11 write in same cycle as update: old config still applies
        cfg_wr = 1'b1; cfg_enable = 1'b0; in_valid = 1'b1; in_word = 6'd60;
        tick();
        cfg_wr = 1'b0; in_valid = 1'b0;
        check("R11", int'(out_word), 6);
        in_valid = 1'b1; in_word = 6'd60;
        tick();
        in_valid = 1'b0;
        check("R11", int'(out_word), 60);

        // R9 K=0 freezes across several words
        cfg_wr = 1'b1; cfg_enable = 1'b1; cfg_step = '0;
        tick();
        cfg_wr = 1'b0;
        for (int i = 0; i < 4; i++) begin
            in_valid = 1'b1; in_word = BW'(i * 17);
            tick();
            in_valid = 1'b0;
            check("R9", int'(out_word), 60);
        end

        // R10 hold while idle
        repeat (5) tick();
        check("R10", int'(out_word), 60);
        check("R2", int'(out_valid), 0);

        // R7 full-range moves
        pair(0, WMAX, 5, "R7");
        pair(WMAX, 0, 5, "R7");

        // Exhaustive sweep: R4 R5 R6 (and R3 R8 per pair)
        foreach (kset[j]) begin
            for (int a = 0; a <= WMAX; a++) begin
                for (int b = 0; b <= WMAX; b++) begin
                    if (b - a > kset[j])       pair(a, b, kset[j], "R4");
                    else if (b - a < -kset[j]) pair(a, b, kset[j], "R5");
                    else                       pair(a, b, kset[j], "R6");
                end
            end
        end

        done = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule